// File: doc/BRIEF.md
# Auto-Detecting Dual-Mode Host Bus Front End

This block sits between an 8-bit parallel microprocessor bus and the core of a serial bus controller. It works with two styles of host. One style uses separate active-low read and write strobes. The other uses a single read/write line and expects a data-acknowledge reply. The block picks the style itself from the first write/chip-select pattern it sees after reset, and keeps that choice until the next reset.

In either style, one address line and a bank-select field in the control register steer accesses across a small register bank. The bank holds three setup registers (own address, clock select and interrupt vector) and two double locations, data and control/status. At a double location a host write lands in write-side storage, and a host read returns separate read-side storage. The serial core fills the read-side storage through simple load ports. It also takes the write-side values and the setup values from output ports.

Chip select and the write line pass through a synchronizer before any edge is detected. The data bus output is combinational from the pins, so a read returns data as long as chip select and the read condition are held.

Top module: `hbi_front`

## Requirements
- R1: While `rst` is high and directly after it, the block is in separate-strobe mode (`mode_o`=0), `dtack_en`=0, `dtack_n`=1 and `db_oe`=0. The write-side data, control and all three setup registers read as 0.
- R2: A falling edge on `wr_n` while `cs_n` is high, seen through the synchronizer, sets `mode_o` to 1 (single read/write-line mode). Once set, `mode_o` stays 1 until reset, whatever `wr_n` and `cs_n` do afterwards.
- R3: In separate-strobe mode, a falling edge on `wr_n` while `cs_n` is low leaves `mode_o` at 0 and commits exactly one write.
- R4: `dtack_en` is 1 only in single-line mode, and in separate-strobe mode `dtack_n` is always 1. In single-line mode `dtack_n` goes low on the third rising clock edge after `cs_n` falls. It returns high on the third rising edge after `cs_n` rises (two synchronizer stages plus one register).
- R5: `db_oe` is 1 only in these cases: during a read with `cs_n` low, or during an honoured interrupt acknowledge. A read with `cs_n` low means `rd_n` low in separate-strobe mode, or `wr_n` (read/write line) high in single-line mode. `db_oe` is 0 during writes and whenever `cs_n` is high with no acknowledge.
- R6: A write with `a0`=1 loads the control write-side register (`ctrl_o`). A read with `a0`=1 returns the status read-side register, which is loaded from `st_data_i` on a cycle with `st_load_i`=1.
- R7: With the bank field `ctrl_o[5:4]`=00, a write with `a0`=0 loads `tx_data_o`. A read with `a0`=0 returns the receive read-side register, loaded from `rx_data_i` on a cycle with `rx_load_i`=1, and never the value last written.
- R8: With `a0`=0, bank field values 01, 10 and 11 select the own-address, clock-select and interrupt-vector registers for both write and read. These registers appear on `own_addr_o`, `clk_sel_o` and `vec_o`.
- R9: With `iack_n` low, the block drives `vec_o` onto `db_out` with `db_oe`=1, but only when it is honoured: in single-line mode, or in separate-strobe mode when `IACK_IN_STROBE`=1. With the default `IACK_IN_STROBE`=0, `iack_n` has no effect in separate-strobe mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Address line: 0 data/bank, 1 control/status |
| wr_n | input | 1 | Write strobe (strobe mode) or read/write line, low = write (single-line mode) |
| rd_n | input | 1 | Read strobe, used in separate-strobe mode only |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| db_in | input | 8 | Data bus from host |
| db_out | output | 8 | Data bus to host |
| db_oe | output | 1 | Data bus drive enable |
| dtack_n | output | 1 | Data acknowledge, active low |
| dtack_en | output | 1 | Drive enable of the acknowledge pin |
| rx_load_i | input | 1 | Load receive read-side register |
| rx_data_i | input | 8 | Received byte from the serial core |
| st_load_i | input | 1 | Load status read-side register |
| st_data_i | input | 8 | Status byte from the serial core |
| mode_o | output | 1 | 0 separate-strobe, 1 single read/write-line |
| tx_data_o | output | 8 | Data write-side register |
| ctrl_o | output | 8 | Control write-side register |
| own_addr_o | output | 8 | Own-address setup register |
| clk_sel_o | output | 8 | Clock-select setup register |
| vec_o | output | 8 | Interrupt-vector setup register |

## Verification
The assertions check several properties on every cycle:
- The mode latch never falls back until reset.
- Each switch to single-line mode follows a cycle with synchronized chip select high.
- The acknowledge pin stays silent in strobe mode and tracks synchronized chip select in single-line mode.
- The data bus is driven only with chip select or acknowledge active.
- An unhonoured acknowledge is ignored.

Only the bench scenarios can show the rest:
- The three-edge acknowledge timing at the pins.
- That a strobe-mode write with chip select low does not switch modes.
- That double locations return read-side data distinct from what was written.
- The bank-select decode across all four field values in both bus styles.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    localparam int DW      = 8;
    localparam int SEL_LSB = 4;
    localparam int SEL_W   = 2;

    typedef enum logic {
        MODE_STROBE = 1'b0,
        MODE_RW     = 1'b1
    } bus_mode_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_OWN  = 2'd1,
        SEL_CLK  = 2'd2,
        SEL_VEC  = 2'd3
    } bank_sel_e;

    // synchronized host pins
    typedef struct packed {
        logic cs_n;
        logic wr_n;
    } host_pins_t;

    function automatic bank_sel_e sel_of(input logic [DW-1:0] ctrl);
        return bank_sel_e'(ctrl[SEL_LSB +: SEL_W]);
    endfunction

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int         W      = 2,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{INIT}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbi_mode_det.sv
module hbi_mode_det
    import hbi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  host_pins_t pins_s,
    output bus_mode_e  mode
);
    logic wr_prev;
    logic wr_fall;

    assign wr_fall = wr_prev && !pins_s.wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev <= 1'b1;
            mode    <= MODE_STROBE;
        end else begin
            wr_prev <= pins_s.wr_n;
            if (mode == MODE_STROBE && wr_fall && pins_s.cs_n) begin
                mode <= MODE_RW;
            end
        end
    end
endmodule

// File: rtl/hbi_cycle.sv
module hbi_cycle
    import hbi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_mode_e  mode,
    input  host_pins_t pins_s,
    output logic       wr_stb,
    output logic       dtack_n
);
    logic wr_act;
    logic wr_act_q;

    // write access: chip selected with write line low (same in both styles)
    assign wr_act = !pins_s.cs_n && !pins_s.wr_n;
    assign wr_stb = wr_act && !wr_act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_act_q <= 1'b0;
            dtack_n  <= 1'b1;
        end else begin
            wr_act_q <= wr_act;
            dtack_n  <= (mode == MODE_RW) ? pins_s.cs_n : 1'b1;
        end
    end
endmodule

// File: rtl/hbi_regbank.sv
module hbi_regbank
    import hbi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic          wr_a0,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_a0,
    input  logic          rx_load,
    input  logic [DW-1:0] rx_data,
    input  logic          st_load,
    input  logic [DW-1:0] st_data,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] tx_q,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] own_q,
    output logic [DW-1:0] clk_q,
    output logic [DW-1:0] vec_q
);
    localparam int N_SETUP = 3;

    bank_sel_e     sel;
    logic [DW-1:0] rx_q;
    logic [DW-1:0] st_q;
    logic          wr_bank;

    assign sel     = sel_of(ctrl_q);
    assign wr_bank = wr_stb && !wr_a0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            st_q   <= '0;
        end else begin
            if (wr_stb && wr_a0)                ctrl_q <= wr_data;
            if (wr_bank && sel == SEL_DATA)     tx_q   <= wr_data;
            if (rx_load)                        rx_q   <= rx_data;
            if (st_load)                        st_q   <= st_data;
        end
    end

    for (genvar g = 0; g < N_SETUP; g++) begin : g_setup
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_bank && sel == bank_sel_e'(g + 1)) begin
                q <= wr_data;
            end
        end
    end

    assign own_q = g_setup[0].q;
    assign clk_q = g_setup[1].q;
    assign vec_q = g_setup[2].q;

    always_comb begin
        if (rd_a0) begin
            rd_data = st_q;
        end else begin
            unique case (sel)
                SEL_DATA: rd_data = rx_q;
                SEL_OWN:  rd_data = own_q;
                SEL_CLK:  rd_data = clk_q;
                SEL_VEC:  rd_data = vec_q;
                default:  rd_data = rx_q;
            endcase
        end
    end
endmodule

// File: rtl/hbi_front.sv
module hbi_front
    import hbi_pkg::*;
#(
    parameter int   SYNC_STAGES    = 2,
    parameter logic IACK_IN_STROBE = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          a0,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          iack_n,
    input  logic [DW-1:0] db_in,
    output logic [DW-1:0] db_out,
    output logic          db_oe,
    output logic          dtack_n,
    output logic          dtack_en,
    input  logic          rx_load_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic          st_load_i,
    input  logic [DW-1:0] st_data_i,
    output logic          mode_o,
    output logic [DW-1:0] tx_data_o,
    output logic [DW-1:0] ctrl_o,
    output logic [DW-1:0] own_addr_o,
    output logic [DW-1:0] clk_sel_o,
    output logic [DW-1:0] vec_o
);
    host_pins_t    pins_raw;
    host_pins_t    pins_s;
    bus_mode_e     mode;
    logic          wr_stb;
    logic          cs_s;
    logic [DW-1:0] rd_data;
    logic          rd_req;
    logic          iack_ok;

    assign pins_raw = '{cs_n: cs_n, wr_n: wr_n};
    assign cs_s     = pins_s.cs_n;

    hbi_sync #(
        .W      ($bits(host_pins_t)),
        .STAGES (SYNC_STAGES),
        .INIT   ('1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    hbi_mode_det u_mode (
        .clk    (clk),
        .rst    (rst),
        .pins_s (pins_s),
        .mode   (mode)
    );

    hbi_cycle u_cycle (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .pins_s  (pins_s),
        .wr_stb  (wr_stb),
        .dtack_n (dtack_n)
    );

    hbi_regbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_a0   (a0),
        .wr_data (db_in),
        .rd_a0   (a0),
        .rx_load (rx_load_i),
        .rx_data (rx_data_i),
        .st_load (st_load_i),
        .st_data (st_data_i),
        .rd_data (rd_data),
        .tx_q    (tx_data_o),
        .ctrl_q  (ctrl_o),
        .own_q   (own_addr_o),
        .clk_q   (clk_sel_o),
        .vec_q   (vec_o)
    );

    always_comb begin
        if (mode == MODE_RW) begin
            rd_req = !cs_n && wr_n;
        end else begin
            rd_req = !cs_n && !rd_n;
        end
    end

    assign iack_ok  = !iack_n && (mode == MODE_RW || IACK_IN_STROBE);
    assign db_oe    = rd_req || iack_ok;
    assign db_out   = iack_ok ? vec_o : rd_data;
    assign mode_o   = (mode == MODE_RW);
    assign dtack_en = mode_o;
endmodule

// File: rtl/hbi_front_chk.sv
module hbi_front_chk #(
    parameter logic IACK_IN_STROBE = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic iack_n,
    input logic cs_s,
    input logic mode_o,
    input logic dtack_n,
    input logic dtack_en,
    input logic db_oe
);
    AST_MODE_LATCHED: assert property (@(posedge clk) disable iff (rst)
        mode_o |=> mode_o); // R2

    AST_SWITCH_NEEDS_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_o) |-> $past(cs_s)); // R2

    AST_DTACK_QUIET_STROBE: assert property (@(posedge clk) disable iff (rst)
        !mode_o |-> (dtack_n && !dtack_en)); // R4

    AST_DTACK_FOLLOWS_CS: assert property (@(posedge clk) disable iff (rst)
        (mode_o && !cs_s) |=> !dtack_n); // R4

    AST_DTACK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> $past(!cs_s)); // R4

    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        db_oe |-> (!cs_n || !iack_n)); // R5

    AST_IACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!mode_o && !IACK_IN_STROBE && cs_n) |-> !db_oe); // R9
endmodule

bind hbi_front hbi_front_chk #(.IACK_IN_STROBE(IACK_IN_STROBE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .iack_n   (iack_n),
    .cs_s     (cs_s),
    .mode_o   (mode_o),
    .dtack_n  (dtack_n),
    .dtack_en (dtack_en),
    .db_oe    (db_oe)
);

// File: tb/hbi_front_tb.sv
module hbi_front_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, a0 = 1'b0, wr_n = 1'b1, rd_n = 1'b1, iack_n = 1'b1;
    logic [7:0] db_in = '0;
    logic [7:0] db_out;
    logic       db_oe, dtack_n, dtack_en;
    logic       rx_load_i = 1'b0, st_load_i = 1'b0;
    logic [7:0] rx_data_i = '0, st_data_i = '0;
    logic       mode_o;
    logic [7:0] tx_data_o, ctrl_o, own_addr_o, clk_sel_o, vec_o;

    int n_cmp = 0;
    int n_err = 0;
    bit rw_mode = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hbi_front u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .a0(a0), .wr_n(wr_n), .rd_n(rd_n),
        .iack_n(iack_n), .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
        .dtack_n(dtack_n), .dtack_en(dtack_en), .rx_load_i(rx_load_i),
        .rx_data_i(rx_data_i), .st_load_i(st_load_i), .st_data_i(st_data_i),
        .mode_o(mode_o), .tx_data_o(tx_data_o), .ctrl_o(ctrl_o),
        .own_addr_o(own_addr_o), .clk_sel_o(clk_sel_o), .vec_o(vec_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_ne(input string req, input logic [7:0] act, input logic [7:0] bad);
        n_cmp++;
        if (act === bad) begin
            n_err++;
            $display("FAIL %s actual=%h expected=not %h", req, act, bad);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; iack_n = 1'b1;
        wait_n(3);
        rst = 1'b0;
        rw_mode = 1'b0;
        wait_n(2);
    endtask

    task automatic host_write(input logic addr, input logic [7:0] d);
        a0 = addr; db_in = d;
        if (!rw_mode) begin
            cs_n = 1'b0; wait_n(3);
            wr_n = 1'b0; wait_n(4);
            wr_n = 1'b1; wait_n(3);
            cs_n = 1'b1; wait_n(3);
        end else begin
            wr_n = 1'b0; wait_n(3);
            cs_n = 1'b0; wait_n(2);
            chk("R5 no drive during write", {7'b0, db_oe}, 8'h00);
            wait_n(2);
            cs_n = 1'b1; wait_n(3);
            wr_n = 1'b1; wait_n(3);
        end
    endtask

    task automatic host_read(input logic addr, output logic [7:0] d, output logic oe);
        a0 = addr;
        if (!rw_mode) begin
            cs_n = 1'b0; wait_n(3);
            rd_n = 1'b0; wait_n(2);
            #1; d = db_out; oe = db_oe;
            @(negedge clk);
            rd_n = 1'b1; wait_n(1);
            cs_n = 1'b1; wait_n(3);
        end else begin
            wr_n = 1'b1;
            cs_n = 1'b0; wait_n(4);
            #1; d = db_out; oe = db_oe;
            @(negedge clk);
            cs_n = 1'b1; wait_n(4);
        end
    endtask

    task automatic load_rx(input logic [7:0] v);
        rx_data_i = v; rx_load_i = 1'b1; @(negedge clk); rx_load_i = 1'b0;
    endtask

    task automatic load_st(input logic [7:0] v);
        st_data_i = v; st_load_i = 1'b1; @(negedge clk); st_load_i = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    endtask

    // sweeps shared by both bus styles
    task automatic sweep_bank(input string tag);
        logic [7:0] r;
        logic oe;
        // R6: control write side vs status read side
        for (int i = 0; i < 8; i++) begin
            logic [7:0] cv = 8'((i * 37) & 8'hCF);
            logic [7:0] sv = 8'(~(i * 13));
            host_write(1'b1, cv);
            chk({"R6 ctrl write ", tag}, ctrl_o, cv);
            load_st(sv);
            host_read(1'b1, r, oe);
            chk({"R6 status read ", tag}, r, sv);
            chk({"R5 oe on read ", tag}, {7'b0, oe}, 8'h01);
        end
        host_write(1'b1, 8'h00);
        // R7: data write side vs receive read side
        for (int i = 0; i < 16; i++) begin
            logic [7:0] tv = 8'(i * 17 + 3);
            logic [7:0] rv = tv ^ 8'h5A;
            host_write(1'b0, tv);
            chk({"R7 tx write ", tag}, tx_data_o, tv);
            load_rx(rv);
            host_read(1'b0, r, oe);
            chk({"R7 rx read ", tag}, r, rv);
            chk_ne({"R7 read not write side ", tag}, r, tv);
        end
        // R8: bank select field ctrl[5:4]
        for (int s = 1; s < 4; s++) begin
            host_write(1'b1, 8'(s << 4));
            for (int k = 0; k < 4; k++) begin
                logic [7:0] v = 8'(s * 64 + k * 11 + 1);
                logic [7:0] port;
                host_write(1'b0, v);
                port = (s == 1) ? own_addr_o : (s == 2) ? clk_sel_o : vec_o;
                chk({"R8 setup port ", tag}, port, v);
                chk({"R8 data untouched ", tag}, tx_data_o, 8'(15 * 17 + 3));
                host_read(1'b0, r, oe);
                chk({"R8 setup read ", tag}, r, v);
            end
        end
        host_write(1'b1, 8'h00);
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] r;
        logic oe;
        do_reset();
        // R1
        chk("R1 mode", {7'b0, mode_o}, 8'h00);
        chk("R1 dtack_en", {7'b0, dtack_en}, 8'h00);
        chk("R1 dtack_n", {7'b0, dtack_n}, 8'h01);
        chk("R1 db_oe", {7'b0, db_oe}, 8'h00);
        chk("R1 tx", tx_data_o, 8'h00);
        chk("R1 ctrl", ctrl_o, 8'h00);
        chk("R1 own", own_addr_o, 8'h00);
        chk("R1 clk", clk_sel_o, 8'h00);
        chk("R1 vec", vec_o, 8'h00);

        // R3: strobe write with cs low
        host_write(1'b0, 8'hC3);
        chk("R3 mode stays strobe", {7'b0, mode_o}, 8'h00);
        chk("R3 write committed", tx_data_o, 8'hC3);

        sweep_bank("strobe");

        // R5 strobe: rd low with cs high, cs low with rd high
        rd_n = 1'b0; wait_n(3); #1;
        chk("R5 rd without cs", {7'b0, db_oe}, 8'h00);
        rd_n = 1'b1; cs_n = 1'b0; wait_n(3); #1;
        chk("R5 cs without rd", {7'b0, db_oe}, 8'h00);
        chk("R4 dtack quiet strobe", {7'b0, dtack_n}, 8'h01);
        cs_n = 1'b1; wait_n(3);
        // R9 strobe: iack ignored
        iack_n = 1'b0; wait_n(3); #1;
        chk("R9 iack ignored strobe", {7'b0, db_oe}, 8'h00);
        iack_n = 1'b1; wait_n(2);
        chk("R2 still strobe", {7'b0, mode_o}, 8'h00);

        // single-line phase
        do_reset();
        chk("R1 setup cleared", vec_o, 8'h00);
        chk("R1 mode after reset", {7'b0, mode_o}, 8'h00);
        wr_n = 1'b0; wait_n(4);
        chk("R2 mode switched", {7'b0, mode_o}, 8'h01);
        chk("R4 dtack_en", {7'b0, dtack_en}, 8'h01);
        chk("R4 dtack idle", {7'b0, dtack_n}, 8'h01);
        wr_n = 1'b1; wait_n(3);
        rw_mode = 1'b1;

        // R4 timing
        cs_n = 1'b0;
        wait_n(2); chk("R4 dtack after 2 edges", {7'b0, dtack_n}, 8'h01);
        wait_n(1); chk("R4 dtack after 3 edges", {7'b0, dtack_n}, 8'h00);
        chk("R5 oe single read", {7'b0, db_oe}, 8'h01);
        cs_n = 1'b1;
        wait_n(2); chk("R4 dtack hold 2 edges", {7'b0, dtack_n}, 8'h00);
        wait_n(1); chk("R4 dtack released", {7'b0, dtack_n}, 8'h01);
        wait_n(2);

        sweep_bank("single");

        // R5 single: rd_n has no role
        rd_n = 1'b0; wait_n(2); #1;
        chk("R5 rd ignored single", {7'b0, db_oe}, 8'h00);
        rd_n = 1'b1;
        // R9 single: iack drives vector
        host_write(1'b1, 8'h30);
        host_write(1'b0, 8'h9E);
        host_write(1'b1, 8'h00);
        iack_n = 1'b0; wait_n(1); #1;
        chk("R9 iack oe", {7'b0, db_oe}, 8'h01);
        chk("R9 iack vector", db_out, 8'h9E);
        iack_n = 1'b1; wait_n(2); #1;
        chk("R9 iack released", {7'b0, db_oe}, 8'h00);

        // R2 latched: more wr falls with cs high
        wr_n = 1'b0; wait_n(4); wr_n = 1'b1; wait_n(4);
        chk("R2 latched", {7'b0, mode_o}, 8'h01);
        host_read(1'b0, r, oe);
        chk("R2 latched after read", {7'b0, mode_o}, 8'h01);

        summary();
    end
endmodule